// File: doc/BRIEF.md
# Audio Sample DMA Engine with Forced Stop

The block moves 32-bit audio samples between memory and a serial audio peripheral in both directions. The playback channel reads words from memory and presents them on a valid/ready output stream. The capture channel accepts words from a valid/ready input stream, holds them in a small FIFO and writes them to memory. Both channels share one request/acknowledge memory port that carries one word per bus cycle. Software programs each channel through a small register file. It writes a start address and a byte count, then sets a start bit.

Software can stop a running channel early. After the stop request, the channel finishes the memory cycle it has in flight. The capture channel also writes every word already in its FIFO to memory. Only after that does the stop bit read back as 0. For the whole time the stop bit reads 1, a start request to that channel has no effect. A sticky status bit records the completed stop and can drive the interrupt line. To resume, software reads the remaining byte count, loads a new address and count, and starts the channel again.

Top module: `aud_dma`

Register map. The index is `cfg_addr`. Reads return data one cycle after the index is presented.
- 0, CTRL
  - Write: bit0 starts playback; bit1 starts capture; bit2 requests a playback stop; bit3 requests a capture stop; bit4 is the playback interrupt enable; bit5 is the capture interrupt enable. Bits 0 to 3 are one-shot. Bits 4 and 5 are stored on every write to CTRL.
  - Read: bit0 playback running; bit1 capture running; bit2 playback stop pending; bit3 capture stop pending; bits 5:4 are the interrupt enables.
- 1, STAT. Sticky bits, each cleared by writing 1 to it: bit0 playback stop complete; bit1 capture stop complete; bit2 playback count finished; bit3 capture count finished.
- 2, playback source address.
- 3, playback byte count.
- 4, capture destination address.
- 5, capture byte count.
- 6, playback remaining bytes. Read-only.
- 7, capture remaining bytes. Read-only.

## Requirements
- R1: After reset, CTRL, STAT and both remaining counts read 0, and `mem_req`, `irq`, `tx_valid` and `rx_ready` are all 0.
- R2: A playback start with count N reads N/4 words from the source address upward in steps of 4. It presents them in that order on `tx_data`. When the last word is accepted, it clears CTRL bit0 and sets STAT bit2.
- R3: A capture start with count N accepts exactly N/4 words on the input stream. It writes them in arrival order to the destination address upward in steps of 4 (`mem_we`=1). When the last write is acknowledged, it clears CTRL bit1 and sets STAT bit3.
- R4: A channel's remaining count (index 6 or 7) loads the byte count at start. It drops by 4 on each acknowledged memory cycle of that channel and holds its value once the channel has stopped.
- R5: After a playback stop request, a memory read already in flight is carried to its acknowledge, with `mem_req` held high. CTRL bit2 reads 1 until that acknowledge. After the stop, no further reads are issued and no fetched word reaches the output stream.
- R6: After a capture stop request, `rx_ready` stays low. CTRL bit3 reads 1 until every word already in the FIFO has been written to memory.
- R7: A start written while that channel's stop bit reads 1 is ignored. After the stop completes, the channel's running bit is 0 and it issues no memory cycles.
- R8: STAT bit0 or bit1 is set only when the stop has completed, not when it is requested. `irq` is the OR of STAT bit0 AND CTRL bit4 with STAT bit1 AND CTRL bit5. Writing 1 to a STAT bit clears it.
- R9: After a stop, loading a new address and count and starting again resumes the transfer. The resumed transfer behaves as in R2 and R3.
- R10: The capture FIFO holds 8 words. While memory does not acknowledge, exactly 8 input words are accepted before `rx_ready` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, registered |
| mem_req | output | 1 | Memory cycle request, held until acknowledge |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory cycle complete |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| tx_valid | output | 1 | Playback word valid |
| tx_data | output | 32 | Playback word |
| tx_ready | input | 1 | Peripheral accepts playback word |
| rx_valid | input | 1 | Capture word valid |
| rx_data | input | 32 | Capture word |
| rx_ready | output | 1 | Engine accepts capture word |
| irq | output | 1 | Stop-complete interrupt, registered |

## Verification
The bench stops the capture channel while memory is stalled with a full FIFO. A design that cleared the stop bit early would lose those eight words, leave the wrong remaining count, or raise the interrupt while writes are still outstanding. It sends a start during the pending stop. A design that did not gate the start would keep capturing after the stop. It stops playback with a slow read in flight. A design that abandoned the bus cycle, or still passed the fetched word on, would show the wrong read count, the wrong remaining count, or a spurious output word. A resume from the reported remaining count checks that the second transfer continues the word sequence at the new address.

// File: rtl/aud_dma_pkg.sv
package aud_dma_pkg;
  localparam int REG_W = 32;

  localparam logic [2:0] REG_CTRL    = 3'd0;
  localparam logic [2:0] REG_STAT    = 3'd1;
  localparam logic [2:0] REG_TX_ADDR = 3'd2;
  localparam logic [2:0] REG_TX_CNT  = 3'd3;
  localparam logic [2:0] REG_RX_ADDR = 3'd4;
  localparam logic [2:0] REG_RX_CNT  = 3'd5;
  localparam logic [2:0] REG_TX_LEFT = 3'd6;
  localparam logic [2:0] REG_RX_LEFT = 3'd7;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_TX   = 2'd1,
    OWN_RX   = 2'd2
  } bus_owner_e;
endpackage

// File: rtl/aud_dma_fifo.sv
module aud_dma_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0]      wr_p, rd_p;

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem_q[wr_p[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_p <= '0;
      rd_p <= '0;
    end else begin
      if (push) wr_p <= wr_p + 1'b1;
      if (pop)  rd_p <= rd_p + 1'b1;
    end
  end

  assign dout  = mem_q[rd_p[AW-1:0]];
  assign empty = (wr_p == rd_p);
  assign full  = (wr_p[AW] != rd_p[AW]) && (wr_p[AW-1:0] == rd_p[AW-1:0]);

  // R10: the capture side never writes into a full buffer
  a_r10_no_push_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/aud_dma_arb.sv
module aud_dma_arb
  import aud_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_req,
  input  logic [ADDR_W-1:0] tx_addr,
  output logic              tx_ack,
  input  logic              rx_req,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [DATA_W-1:0] rx_wdata,
  output logic              rx_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack
);
  bus_owner_e own_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q     <= OWN_NONE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (own_q == OWN_NONE) begin
      // capture first: its FIFO is the side that can fill up
      if (rx_req) begin
        own_q     <= OWN_RX;
        mem_req   <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= rx_addr;
        mem_wdata <= rx_wdata;
      end else if (tx_req) begin
        own_q     <= OWN_TX;
        mem_req   <= 1'b1;
        mem_we    <= 1'b0;
        mem_addr  <= tx_addr;
        mem_wdata <= '0;
      end
    end else if (mem_ack) begin
      own_q   <= OWN_NONE;
      mem_req <= 1'b0;
    end
  end

  assign tx_ack = mem_ack && (own_q == OWN_TX);
  assign rx_ack = mem_ack && (own_q == OWN_RX);

  // R5: a bus cycle once started is never abandoned or altered
  a_r5_bus_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

// File: rtl/aud_dma_txch.sv
module aud_dma_txch #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_cnt,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              en,
  output logic              stop_pend,
  output logic [CNT_W-1:0]  left,
  output logic              term_p,
  output logic              done_p
);
  localparam int STEP = DATA_W / 8;

  logic stop_now, fin_now;

  assign stop_now = stop_pend && (!bus_req || bus_ack);
  assign fin_now  = en && !stop_pend && !bus_req && (left == '0) &&
                    (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      stop_pend <= 1'b0;
      bus_req   <= 1'b0;
      bus_addr  <= '0;
      left      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      term_p    <= 1'b0;
      done_p    <= 1'b0;
    end else begin
      term_p <= 1'b0;
      done_p <= 1'b0;
      if (!en) begin
        if (start && !stop_pend) begin
          en       <= 1'b1;
          bus_addr <= cfg_addr;
          left     <= cfg_cnt;
        end
      end else begin
        if (stop && !stop_pend) stop_pend <= 1'b1;
        if (bus_req && bus_ack) begin
          bus_req   <= 1'b0;
          bus_addr  <= bus_addr + ADDR_W'(STEP);
          left      <= left - CNT_W'(STEP);
          out_data  <= bus_rdata;
          out_valid <= !stop_pend;
        end
        if (out_valid && out_ready) out_valid <= 1'b0;
        if (!stop_pend && !bus_req && !out_valid && (left != '0))
          bus_req <= 1'b1;
        if (stop_now) begin
          stop_pend <= 1'b0;
          en        <= 1'b0;
          out_valid <= 1'b0;
          term_p    <= 1'b1;
        end else if (fin_now) begin
          en     <= 1'b0;
          done_p <= 1'b1;
        end
      end
    end
  end

  // R5: the stop stays pending while the read has not been acknowledged
  a_r5_stop_waits_ack: assert property (@(posedge clk) disable iff (rst)
    stop_pend && bus_req && !bus_ack |=> stop_pend);
  // R4: each acknowledged read takes one word off the remaining count
  a_r4_left_step: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> left == $past(left) - CNT_W'(STEP));
endmodule

// File: rtl/aud_dma_rxch.sv
module aud_dma_rxch #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_cnt,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              en,
  output logic              stop_pend,
  output logic [CNT_W-1:0]  left,
  output logic              term_p,
  output logic              done_p
);
  localparam int STEP = DATA_W / 8;

  logic [CNT_W-1:0] cap_q;
  logic             f_empty, f_full, push, pop, stop_now, fin_now;

  assign in_ready = en && !stop_pend && !f_full && (cap_q != '0);
  assign push     = in_valid && in_ready;
  assign pop      = bus_req && bus_ack;
  assign stop_now = stop_pend && !bus_req && f_empty;
  assign fin_now  = en && !stop_pend && !bus_req && (left == '0);

  aud_dma_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .din   (in_data),
    .pop   (pop),
    .dout  (bus_wdata),
    .empty (f_empty),
    .full  (f_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      stop_pend <= 1'b0;
      bus_req   <= 1'b0;
      bus_addr  <= '0;
      left      <= '0;
      cap_q     <= '0;
      term_p    <= 1'b0;
      done_p    <= 1'b0;
    end else begin
      term_p <= 1'b0;
      done_p <= 1'b0;
      if (!en) begin
        if (start && !stop_pend) begin
          en       <= 1'b1;
          bus_addr <= cfg_addr;
          left     <= cfg_cnt;
          cap_q    <= cfg_cnt;
        end
      end else begin
        if (stop && !stop_pend) stop_pend <= 1'b1;
        if (push) cap_q <= cap_q - CNT_W'(STEP);
        if (pop) begin
          bus_req  <= 1'b0;
          bus_addr <= bus_addr + ADDR_W'(STEP);
          left     <= left - CNT_W'(STEP);
        end
        if (!bus_req && !f_empty) bus_req <= 1'b1;
        if (stop_now) begin
          stop_pend <= 1'b0;
          en        <= 1'b0;
          term_p    <= 1'b1;
        end else if (fin_now) begin
          en     <= 1'b0;
          done_p <= 1'b1;
        end
      end
    end
  end

  // R6: a capture stop only completes on an empty FIFO
  a_r6_drained: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_pend) |-> f_empty);
  // R3: never more words captured than remain to be written
  a_r3_cap_le_left: assert property (@(posedge clk) disable iff (rst)
    en |-> cap_q <= left);
endmodule

// File: rtl/aud_dma.sv
module aud_dma
  import aud_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              irq
);
  localparam int STEP = DATA_W / 8;

  logic [ADDR_W-1:0] tx_addr_q, rx_addr_q, tx_bus_addr, rx_bus_addr;
  logic [CNT_W-1:0]  tx_cnt_q, rx_cnt_q, tx_left, rx_left;
  logic [DATA_W-1:0] rx_bus_wdata;
  logic [1:0]        ien_q;
  logic [3:0]        sts_q, sts_clr;
  logic              wr_ctrl, tx_start, rx_start, tx_stop, rx_stop;
  logic              tx_en, rx_en, tx_stop_pend, rx_stop_pend;
  logic              tx_term_p, rx_term_p, tx_done_p, rx_done_p;
  logic              tx_bus_req, rx_bus_req, tx_bus_ack, rx_bus_ack;
  logic [REG_W-1:0]  rdata_d;

  assign wr_ctrl  = cfg_we && (cfg_addr == REG_CTRL);
  assign tx_start = wr_ctrl && cfg_wdata[0];
  assign rx_start = wr_ctrl && cfg_wdata[1];
  assign tx_stop  = wr_ctrl && cfg_wdata[2];
  assign rx_stop  = wr_ctrl && cfg_wdata[3];
  assign sts_clr  = (cfg_we && (cfg_addr == REG_STAT)) ? cfg_wdata[3:0] : 4'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q     <= '0;
      sts_q     <= '0;
      tx_addr_q <= '0;
      rx_addr_q <= '0;
      tx_cnt_q  <= '0;
      rx_cnt_q  <= '0;
      irq       <= 1'b0;
    end else begin
      if (wr_ctrl) ien_q <= cfg_wdata[5:4];
      if (cfg_we) begin
        case (cfg_addr)
          REG_TX_ADDR: tx_addr_q <= cfg_wdata[ADDR_W-1:0] & ~ADDR_W'(STEP - 1);
          REG_TX_CNT:  tx_cnt_q  <= cfg_wdata[CNT_W-1:0] & ~CNT_W'(STEP - 1);
          REG_RX_ADDR: rx_addr_q <= cfg_wdata[ADDR_W-1:0] & ~ADDR_W'(STEP - 1);
          REG_RX_CNT:  rx_cnt_q  <= cfg_wdata[CNT_W-1:0] & ~CNT_W'(STEP - 1);
          default: ;
        endcase
      end
      // a new event wins over a clear written in the same cycle
      sts_q <= (sts_q & ~sts_clr) | {rx_done_p, tx_done_p, rx_term_p, tx_term_p};
      irq   <= |(sts_q[1:0] & ien_q);
    end
  end

  always_comb begin
    case (cfg_addr)
      REG_CTRL:    rdata_d = REG_W'({ien_q, rx_stop_pend, tx_stop_pend, rx_en, tx_en});
      REG_STAT:    rdata_d = REG_W'(sts_q);
      REG_TX_ADDR: rdata_d = REG_W'(tx_addr_q);
      REG_TX_CNT:  rdata_d = REG_W'(tx_cnt_q);
      REG_RX_ADDR: rdata_d = REG_W'(rx_addr_q);
      REG_RX_CNT:  rdata_d = REG_W'(rx_cnt_q);
      REG_TX_LEFT: rdata_d = REG_W'(tx_left);
      default:     rdata_d = REG_W'(rx_left);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rdata_d;
  end

  aud_dma_txch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .start     (tx_start),
    .stop      (tx_stop),
    .cfg_addr  (tx_addr_q),
    .cfg_cnt   (tx_cnt_q),
    .bus_req   (tx_bus_req),
    .bus_addr  (tx_bus_addr),
    .bus_ack   (tx_bus_ack),
    .bus_rdata (mem_rdata),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .out_ready (tx_ready),
    .en        (tx_en),
    .stop_pend (tx_stop_pend),
    .left      (tx_left),
    .term_p    (tx_term_p),
    .done_p    (tx_done_p)
  );

  aud_dma_rxch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
                 .FIFO_DEPTH(FIFO_DEPTH)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .start     (rx_start),
    .stop      (rx_stop),
    .cfg_addr  (rx_addr_q),
    .cfg_cnt   (rx_cnt_q),
    .bus_req   (rx_bus_req),
    .bus_addr  (rx_bus_addr),
    .bus_wdata (rx_bus_wdata),
    .bus_ack   (rx_bus_ack),
    .in_valid  (rx_valid),
    .in_data   (rx_data),
    .in_ready  (rx_ready),
    .en        (rx_en),
    .stop_pend (rx_stop_pend),
    .left      (rx_left),
    .term_p    (rx_term_p),
    .done_p    (rx_done_p)
  );

  aud_dma_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .tx_req    (tx_bus_req),
    .tx_addr   (tx_bus_addr),
    .tx_ack    (tx_bus_ack),
    .rx_req    (rx_bus_req),
    .rx_addr   (rx_bus_addr),
    .rx_wdata  (rx_bus_wdata),
    .rx_ack    (rx_bus_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
  );

  // R7: a channel never starts while its stop is still pending
  a_r7_start_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> !$past(tx_stop_pend));
  a_r7_start_gated_rx: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_en) |-> !$past(rx_stop_pend));
  // R8: stop status appears only after the stop bit has cleared
  a_r8_term_late: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_q[1]) |-> !rx_stop_pend);
  a_r8_term_late_tx: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_q[0]) |-> !tx_stop_pend);
endmodule

// File: tb/sim_aud_dma.sv
`timescale 1ns/1ps
module sim_aud_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid;
  logic [31:0] tx_data;
  logic        tx_ready = 1'b0;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_data = '0;
  logic        rx_ready;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mmem [256];
  int dly_set = 2, wait_c = 0, rd_cnt = 0, wr_cnt = 0;
  bit stall = 0, src_on = 0, rx_adv = 0;
  int seq = 0, acc_n = 0, tx_n = 0;
  logic [31:0] acc_log [64];
  logic [31:0] tx_log [64];

  always #4 clk = ~clk;

  aud_dma u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .irq(irq)
  );

  // memory model: acknowledges after dly_set idle cycles unless stalled
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wait_c  = 0;
    end else if (mem_req && !stall) begin
      if (wait_c >= dly_set) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mmem[mem_addr[9:2]] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = mmem[mem_addr[9:2]];
          rd_cnt++;
        end
      end else wait_c++;
    end
  end

  // playback sink log
  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      tx_log[tx_n] = tx_data;
      tx_n++;
    end
  end

  // capture source: advances only after a handshake edge
  always @(negedge clk) begin
    if (rx_adv) seq++;
    rx_data  = 32'hA000_0000 + 32'(seq);
    rx_valid = src_on;
    rx_adv   = rx_valid && rx_ready;
    if (rx_adv) begin
      acc_log[acc_n] = rx_data;
      acc_n++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic wait_bit(logic [2:0] a, int b, logic lvl, string req);
    logic [31:0] v;
    int k;
    for (k = 0; k < 500; k++) begin
      reg_rd(a, v);
      if (v[b] == lvl) break;
    end
    chk(req, 32'(k < 500), 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 rx_ready", 32'(rx_ready), 0);
    reg_rd(3'd0, v); chk("R1 ctrl", v, 0);
    reg_rd(3'd1, v); chk("R1 stat", v, 0);
    reg_rd(3'd6, v); chk("R1 tx_left", v, 0);
    reg_rd(3'd7, v); chk("R1 rx_left", v, 0);
  endtask

  task automatic t_tx_normal();
    logic [31:0] v;
    tx_ready = 1'b1; rd_cnt = 0; tx_n = 0;
    reg_wr(3'd2, 32'h40);
    reg_wr(3'd3, 32'd16);
    reg_wr(3'd0, 32'h1);
    wait_bit(3'd1, 2, 1'b1, "R2 done timeout");
    chk("R2 word count", 32'(tx_n), 4);
    for (int i = 0; i < 4; i++) chk("R2 word order", tx_log[i], 32'h1000_0010 + 32'(i));
    chk("R2 reads", 32'(rd_cnt), 4);
    reg_rd(3'd0, v); chk("R2 running clear", v & 32'h3, 0);
    reg_rd(3'd6, v); chk("R4 tx_left end", v, 0);
    reg_wr(3'd1, 32'h4);
    reg_rd(3'd1, v); chk("R8 w1c done", v, 0);
  endtask

  task automatic t_rx_normal();
    logic [31:0] v;
    wr_cnt = 0; acc_n = 0; src_on = 1;
    reg_wr(3'd4, 32'h100);
    reg_wr(3'd5, 32'd12);
    reg_wr(3'd0, 32'h2);
    wait_bit(3'd1, 3, 1'b1, "R3 done timeout");
    cyc(5);
    chk("R3 accepted", 32'(acc_n), 3);
    chk("R3 writes", 32'(wr_cnt), 3);
    for (int i = 0; i < 3; i++) chk("R3 data", mmem[64 + i], acc_log[i]);
    reg_rd(3'd7, v); chk("R4 rx_left end", v, 0);
    reg_wr(3'd1, 32'h8);
  endtask

  task automatic t_rx_stop();
    logic [31:0] v;
    stall = 1; wr_cnt = 0; acc_n = 0;
    reg_wr(3'd4, 32'h200);
    reg_wr(3'd5, 32'd64);
    reg_wr(3'd0, 32'h22);
    cyc(40);
    chk("R10 fifo depth", 32'(acc_n), 8);
    chk("R10 ready low", 32'(rx_ready), 0);
    reg_wr(3'd0, 32'h28);
    cyc(5);
    reg_wr(3'd0, 32'h22);
    cyc(10);
    chk("R6 no accept", 32'(acc_n), 8);
    chk("R5 bus held", 32'(mem_req), 1);
    reg_rd(3'd0, v); chk("R6 stop pending", 32'(v[3]), 1);
    reg_rd(3'd1, v); chk("R8 no early status", 32'(v[1]), 0);
    chk("R8 no early irq", 32'(irq), 0);
    stall = 0;
    wait_bit(3'd0, 3, 1'b0, "R6 stop timeout");
    cyc(5);
    chk("R6 drained writes", 32'(wr_cnt), 8);
    for (int i = 0; i < 8; i++) chk("R6 drained data", mmem[128 + i], acc_log[i]);
    reg_rd(3'd7, v); chk("R4 rx_left stop", v, 32);
    reg_rd(3'd1, v); chk("R8 status", 32'(v[1]), 1);
    chk("R8 irq", 32'(irq), 1);
    reg_rd(3'd0, v); chk("R7 start ignored", 32'(v[1]), 0);
    cyc(20);
    chk("R7 idle", 32'(wr_cnt), 8);
    chk("R7 no accept", 32'(acc_n), 8);
    reg_rd(3'd7, v); chk("R4 rx_left frozen", v, 32);
    reg_wr(3'd1, 32'h2);
    cyc(3);
    chk("R8 irq cleared", 32'(irq), 0);
    reg_rd(3'd1, v); chk("R8 w1c", 32'(v[1]), 0);
  endtask

  task automatic t_rx_resume();
    logic [31:0] v;
    reg_wr(3'd4, 32'h220);
    reg_wr(3'd5, 32'd32);
    reg_wr(3'd0, 32'h22);
    wait_bit(3'd1, 3, 1'b1, "R9 done timeout");
    cyc(5);
    chk("R9 accepted", 32'(acc_n), 16);
    chk("R9 writes", 32'(wr_cnt), 16);
    for (int i = 0; i < 8; i++) chk("R9 data", mmem[136 + i], acc_log[8 + i]);
    reg_rd(3'd7, v); chk("R9 rx_left", v, 0);
    src_on = 0;
    reg_wr(3'd1, 32'hF);
  endtask

  task automatic t_tx_stop();
    logic [31:0] v;
    tx_ready = 1'b0; dly_set = 20; rd_cnt = 0; tx_n = 0;
    reg_wr(3'd2, 32'h80);
    reg_wr(3'd3, 32'd32);
    reg_wr(3'd0, 32'h11);
    cyc(4);
    reg_wr(3'd0, 32'h14);
    cyc(4);
    chk("R5 read in flight", 32'(mem_req), 1);
    reg_rd(3'd0, v); chk("R5 stop pending", 32'(v[2]), 1);
    reg_rd(3'd1, v); chk("R8 tx no early status", 32'(v[0]), 0);
    chk("R8 tx no early irq", 32'(irq), 0);
    wait_bit(3'd0, 2, 1'b0, "R5 stop timeout");
    cyc(5);
    chk("R5 one read", 32'(rd_cnt), 1);
    reg_rd(3'd6, v); chk("R4 tx_left stop", v, 28);
    reg_rd(3'd1, v); chk("R8 tx status", 32'(v[0]), 1);
    chk("R8 tx irq", 32'(irq), 1);
    reg_rd(3'd0, v); chk("R7 tx idle", 32'(v[0]), 0);
    tx_ready = 1'b1;
    cyc(20);
    chk("R5 no more reads", 32'(rd_cnt), 1);
    chk("R5 no word out", 32'(tx_n), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mmem[i] = 32'h1000_0000 + 32'(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tx_normal();
    t_rx_normal();
    t_rx_stop();
    t_rx_resume();
    t_tx_stop();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule